// File: doc/BRIEF.md
# AC Tweeter Presence Detector

This block decides, for each amplifier channel, whether a capacitively coupled tweeter is still connected. While a high-frequency test tone plays, analog comparators signal every output-current peak that crosses a chosen level. The block counts those peaks during a measuring window. The window opens when the host sets the AC diagnostic enable. It closes at the next host read, and the read latches a per-channel verdict. If fewer than the required number of qualifying peaks were seen, the channel is reported as having an open tweeter.

Each channel has two comparator inputs:

- a high-level comparator that trips near 500 mA;
- a low-level comparator that trips near 250 mA.

A range select picks which comparator counts as the "normal load" threshold. If short-circuit protection fires on a channel during the window, the measurement on that channel is abandoned and no open-tweeter result is reported for it.

A read also starts a fresh window at once when the enable is still set, so repeated reads give back-to-back measurements.

Top module: `ac_tweeter_detect`

## Requirements
- R1: After reset every bit of `openTweeter` is 0 and every channel starts with no counted peaks.
- R2: With the enable high and no protection event, a read after fewer than 3 counted peaks on a channel sets that channel's `openTweeter` bit to 1 (1 means open tweeter; the bit feeds bit 5 of the channel's status byte).
- R3: A read after 3 or more counted peaks clears the channel's bit to 0. The count saturates at 3, so any number of peaks from 3 upward gives the same result.
- R4: With `rangeLow`=0 only rising edges of `cmpHiRaw` (the 500 mA comparator) are counted. With `rangeLow`=1 only rising edges of `cmpLoRaw` (the 250 mA comparator) are counted.
- R5: If `protActive` is high for a channel in any cycle of the window, that channel reads back 0 at the closing read. The next window starts without the abandon mark.
- R6: While `acDiagEn` is low, nothing is counted and the count is held at zero. A read with the enable low returns 0. Dropping and raising the enable discards earlier peaks.
- R7: A read clears every count, so a following read with no new peaks in between reports open.
- R8: A counted edge that falls in the read cycle belongs to the new window, not to the verdict being latched.
- R9: A comparator level held high for many cycles counts as exactly one peak.
- R10: Channels are counted, abandoned and judged independently of one another.
- R11: `openTweeter` changes only in the cycle after a read strobe and holds its value until the next read.
- R12: Changing `rangeLow` while a comparator level is held high creates no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acDiagEn | input | 1 | AC diagnostic enable; high opens the measuring window |
| rangeLow | input | 1 | 0: count 500 mA comparator; 1: count 250 mA comparator |
| cmpHiRaw | input | NUM_CH | Asynchronous 500 mA peak comparator outputs, one per channel |
| cmpLoRaw | input | NUM_CH | Asynchronous 250 mA peak comparator outputs, one per channel |
| protActive | input | NUM_CH | Short-circuit protection active, per channel |
| readStrobe | input | 1 | One-cycle host read strobe; latches verdicts and restarts windows |
| openTweeter | output | NUM_CH | Latched verdict per channel, 1 = open tweeter |

## Verification
Two functions can fall in the same cycle: the close of a window by a read, and the counting of a peak edge (or a protection event) for that channel. The bench first leaves two peaks in a window. It then raises a comparator exactly two cycles before the read strobe, so that its synchronized edge lands on the read edge. The verdict must still say open, because the edge is owed to the next window. The next window must then be confirmed present after only two further peaks, which shows the coinciding edge was carried into it rather than lost.

// File: rtl/tweeter_pkg.sv
package tweeter_pkg;

  // Strobes passed from the window control to the per-channel datapath.
  typedef struct packed {
    logic windowOn;      // measuring window open (enable set)
    logic winClear;      // restart the window: counts and abandon marks reset
    logic latchVerdict;  // capture the verdict of the closing window
  } winCtl_t;

endpackage

// File: rtl/tweeter_ctrl.sv
module tweeter_ctrl
  import tweeter_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    acDiagEn,
  input  logic    readStrobe,
  output winCtl_t ctl
);

  logic enSeen;

  // Tracks the enable so that a window opening is seen as a restart.
  always_ff @(posedge clk) begin
    if (!rst_n) enSeen <= 1'b0;
    else        enSeen <= acDiagEn;
  end

  always_comb begin
    ctl.windowOn     = acDiagEn;
    ctl.latchVerdict = readStrobe;
    ctl.winClear     = readStrobe | !acDiagEn | (acDiagEn & !enSeen);
  end

endmodule

// File: rtl/tweeter_chan.sv
module tweeter_chan
  import tweeter_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int CONFIRM_PULSES = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  winCtl_t ctl,
  input  logic    rangeLow,
  input  logic    cmpHiRaw,
  input  logic    cmpLoRaw,
  input  logic    protActive,
  output logic    openTweeter
);

  localparam int CNT_W = $clog2(CONFIRM_PULSES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CONFIRM_PULSES);

  logic [SYNC_STAGES-1:0] hiSync, loSync;
  logic hiPrev, loPrev;
  logic hiRise, loRise, selRise;
  logic [CNT_W-1:0] pulseCnt;
  logic abandoned;
  logic openReg;

  // Synchronizers and edge history for both comparators.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiSync <= '0;
      loSync <= '0;
      hiPrev <= 1'b0;
      loPrev <= 1'b0;
    end else begin
      hiSync <= {hiSync[SYNC_STAGES-2:0], cmpHiRaw};
      loSync <= {loSync[SYNC_STAGES-2:0], cmpLoRaw};
      hiPrev <= hiSync[SYNC_STAGES-1];
      loPrev <= loSync[SYNC_STAGES-1];
    end
  end

  // Edges are found per comparator first and selected afterwards, so a range
  // change alone never forms an edge.
  always_comb begin
    hiRise  = hiSync[SYNC_STAGES-1] & ~hiPrev;
    loRise  = loSync[SYNC_STAGES-1] & ~loPrev;
    selRise = rangeLow ? loRise : hiRise;
  end

  // Saturating peak counter; an edge in a restart cycle seeds the new window.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulseCnt <= '0;
    end else if (ctl.winClear) begin
      pulseCnt <= (ctl.windowOn && selRise) ? CNT_W'(1) : '0;
    end else if (ctl.windowOn && selRise && pulseCnt != CNT_TOP) begin
      pulseCnt <= pulseCnt + CNT_W'(1);
    end
  end

  // Abandon mark set by protection activity inside the window.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abandoned <= 1'b0;
    end else if (ctl.winClear) begin
      abandoned <= ctl.windowOn & protActive;
    end else if (ctl.windowOn && protActive) begin
      abandoned <= 1'b1;
    end
  end

  // Verdict register, written only on a read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      openReg <= 1'b0;
    end else if (ctl.latchVerdict) begin
      openReg <= ctl.windowOn && !abandoned && (pulseCnt < CNT_TOP);
    end
  end

  assign openTweeter = openReg;

  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseCnt == CNT_TOP && !ctl.winClear) |=> (pulseCnt == CNT_TOP));

  assert_abandon_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.latchVerdict && abandoned) |=> !openTweeter);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.windowOn |=> (pulseCnt == '0));

  assert_fresh_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.latchVerdict |=> (pulseCnt <= CNT_W'(1)));

  assert_verdict_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.latchVerdict |=> $stable(openTweeter));

endmodule

// File: rtl/tweeter_datapath.sv
module tweeter_datapath
  import tweeter_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int SYNC_STAGES    = 2,
  parameter int CONFIRM_PULSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  winCtl_t           ctl,
  input  logic              rangeLow,
  input  logic [NUM_CH-1:0] cmpHiRaw,
  input  logic [NUM_CH-1:0] cmpLoRaw,
  input  logic [NUM_CH-1:0] protActive,
  output logic [NUM_CH-1:0] openTweeter
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tweeter_chan #(
      .SYNC_STAGES   (SYNC_STAGES),
      .CONFIRM_PULSES(CONFIRM_PULSES)
    ) i_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .rangeLow   (rangeLow),
      .cmpHiRaw   (cmpHiRaw[ch]),
      .cmpLoRaw   (cmpLoRaw[ch]),
      .protActive (protActive[ch]),
      .openTweeter(openTweeter[ch])
    );
  end

endmodule

// File: rtl/ac_tweeter_detect.sv
module ac_tweeter_detect
  import tweeter_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int SYNC_STAGES    = 2,
  parameter int CONFIRM_PULSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acDiagEn,
  input  logic              rangeLow,
  input  logic [NUM_CH-1:0] cmpHiRaw,
  input  logic [NUM_CH-1:0] cmpLoRaw,
  input  logic [NUM_CH-1:0] protActive,
  input  logic              readStrobe,
  output logic [NUM_CH-1:0] openTweeter
);

  winCtl_t ctl;

  tweeter_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acDiagEn  (acDiagEn),
    .readStrobe(readStrobe),
    .ctl       (ctl)
  );

  tweeter_datapath #(
    .NUM_CH        (NUM_CH),
    .SYNC_STAGES   (SYNC_STAGES),
    .CONFIRM_PULSES(CONFIRM_PULSES)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .rangeLow   (rangeLow),
    .cmpHiRaw   (cmpHiRaw),
    .cmpLoRaw   (cmpLoRaw),
    .protActive (protActive),
    .openTweeter(openTweeter)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (openTweeter == '0));

endmodule

// File: tb/test_ac_tweeter_detect.sv
module test_ac_tweeter_detect;
  localparam int NUM_CH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic acDiagEn, rangeLow, readStrobe;
  logic [NUM_CH-1:0] cmpHiRaw, cmpLoRaw, protActive, openTweeter;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ac_tweeter_detect #(.NUM_CH(NUM_CH)) i_ac_tweeter_detect (
    .clk(clk), .rst_n(rst_n), .acDiagEn(acDiagEn), .rangeLow(rangeLow),
    .cmpHiRaw(cmpHiRaw), .cmpLoRaw(cmpLoRaw), .protActive(protActive),
    .readStrobe(readStrobe), .openTweeter(openTweeter)
  );

  task automatic check(input string req, input logic [NUM_CH-1:0] got,
                       input logic [NUM_CH-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: openTweeter=%b expected %b", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One peak per channel in mask on the chosen comparator (hi=1: 500 mA).
  task automatic pulses(input logic [NUM_CH-1:0] mask, input bit hi, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hi) cmpHiRaw = mask; else cmpLoRaw = mask;
      idle(3);
      if (hi) cmpHiRaw = '0; else cmpLoRaw = '0;
      idle(3);
    end
  endtask

  task automatic hostRead();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset state", openTweeter, '0);
    hostRead();  // opens clean windows
  endtask

  task automatic t_counts();
    pulses(4'b1100, 1'b1, 2);
    pulses(4'b1101, 1'b1, 1);
    pulses(4'b1000, 1'b1, 2);
    hostRead();  // counts ch0=1 ch1=0 ch2=3 ch3=5
    check("R2/R3/R10 mixed counts", openTweeter, 4'b0011);
  endtask

  task automatic t_hold();
    idle(10);
    check("R11 verdict held between reads", openTweeter, 4'b0011);
    hostRead();
    check("R7 read clears counts", openTweeter, 4'b1111);
  endtask

  task automatic t_range();
    rangeLow = 1'b0;
    pulses(4'b1111, 1'b0, 3);
    hostRead();
    check("R4 range0 ignores 250mA comparator", openTweeter, 4'b1111);
    rangeLow = 1'b1;
    hostRead();
    pulses(4'b1111, 1'b0, 3);
    hostRead();
    check("R4 range1 counts 250mA comparator", openTweeter, 4'b0000);
    pulses(4'b1111, 1'b1, 3);
    hostRead();
    check("R4 range1 ignores 500mA comparator", openTweeter, 4'b1111);
    rangeLow = 1'b0;
    hostRead();
  endtask

  task automatic t_long();
    @(negedge clk) cmpHiRaw = '1;
    idle(20);
    cmpHiRaw = '0;
    idle(3);
    hostRead();
    check("R9 long level counts once", openTweeter, 4'b1111);
  endtask

  task automatic t_rangeSwitch();
    @(negedge clk) cmpLoRaw = '1;
    idle(4);
    for (int i = 0; i < 3; i++) begin
      rangeLow = 1'b1; idle(3);
      rangeLow = 1'b0; idle(3);
    end
    cmpLoRaw = '0;
    idle(3);
    hostRead();
    check("R12 range switch makes no count", openTweeter, 4'b1111);
  endtask

  task automatic t_protect();
    pulses(4'b1111, 1'b1, 1);
    @(negedge clk) protActive = 4'b0010;
    idle(2);
    protActive = '0;
    idle(2);
    hostRead();
    check("R5 abandoned channel reports 0", openTweeter, 4'b1101);
    hostRead();
    check("R5 abandon mark cleared next window", openTweeter, 4'b1111);
  endtask

  task automatic t_enable();
    acDiagEn = 1'b0;
    pulses(4'b1111, 1'b1, 5);
    hostRead();
    check("R6 read with enable low", openTweeter, 4'b0000);
    acDiagEn = 1'b1;
    pulses(4'b1111, 1'b1, 2);
    @(negedge clk) acDiagEn = 1'b0;
    idle(2);
    acDiagEn = 1'b1;
    pulses(4'b1111, 1'b1, 2);
    hostRead();
    check("R6 enable cycle discards peaks", openTweeter, 4'b1111);
  endtask

  task automatic t_coincide();
    pulses(4'b1111, 1'b1, 2);
    @(negedge clk) cmpHiRaw = '1;
    @(negedge clk);
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
    check("R8 read-cycle edge not in closing verdict", openTweeter, 4'b1111);
    idle(2);
    cmpHiRaw = '0;
    idle(3);
    pulses(4'b1111, 1'b1, 2);
    hostRead();
    check("R8 read-cycle edge carried to new window", openTweeter, 4'b0000);
  endtask

  initial begin
    rst_n = 1'b0; acDiagEn = 1'b0; rangeLow = 1'b0; readStrobe = 1'b0;
    cmpHiRaw = '0; cmpLoRaw = '0; protActive = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    acDiagEn = 1'b1;
    t_reset();
    t_counts();
    t_hold();
    t_range();
    t_long();
    t_rangeSwitch();
    t_protect();
    t_enable();
    t_coincide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule